// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block produces the single interrupt line of a serial flash controller that owns three queues: a 32-bit command queue, a byte-wide transmit FIFO and a byte-wide receive FIFO. It watches the occupancy count and the full and empty flags of each queue, and it compares each count against a programmable threshold. It also takes three one-cycle event pulses from the FIFO logic: receive overflow, transmit underflow and mode fault.

The results land in a 12-bit status register. The three event bits are sticky. Every other bit is rebuilt from the live FIFO state on each clock. Software masks sources through two write-only strobes. One strobe sets bits in the mask and the other clears them. The mask itself can be read but not written. The interrupt is registered. It is the OR of the unmasked status bits, gated by a fixed source-enable pattern of 0xFBE.

All registers sit on one word-wide port, with a write strobe and a combinational read. Word addresses are 0 for status (read, write-1-to-clear), 1 for unmask, 2 for mask-set, 3 for the mask (read-only), 4 for the transmit threshold, 5 for the receive threshold and 6 for the command threshold. Reads of addresses 1, 2 and 7 return zero.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset, the mask reads 0xFBE, all three thresholds read 1, the interrupt is low, and with empty idle FIFOs the status reads 0xB84.
- R2: Status bits follow the FIFO flags one clock after the flags change: bit 3 TX full, bit 5 RX full, bit 7 command empty, bit 8 TX empty, bit 10 command full, bit 11 RX empty.
- R3: Status bit 4 (RX level) is 1 exactly when the RX count is greater than or equal to the RX threshold (address 5). It follows changes one clock later.
- R4: Status bit 2 is 1 exactly when the TX count is strictly below the TX threshold (address 4). Status bit 9 is 1 exactly when the command count is strictly below the command threshold (address 6).
- R5: A one-cycle pulse on ev_rx_overflow, ev_mode_fail or ev_tx_underflow sets status bit 0, 1 or 6 respectively. The bit then stays set until it is cleared.
- R6: Writing the status address clears each sticky bit written as 1. Level bits (2, 3, 4, 5, 7 to 11) are not affected by such a write.
- R7: When a sticky event pulse and a clearing write of the same bit fall in the same cycle, the bit ends up set.
- R8: Writing address 2 ORs the written low 12 bits into the mask. Writing address 1 clears the written bits from the mask. A write to address 3 leaves the mask unchanged.
- R9: The interrupt equals the OR over bits of (NOT mask) AND status AND 0xFBE, one clock after the status and mask values it is computed from. Status bits 0 and 6 therefore never raise it.
- R10: The interrupt is low in the cycle after any clock edge that samples reset active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cmd_count | input | 6 | Command queue occupancy |
| cmd_full | input | 1 | Command queue full |
| cmd_empty | input | 1 | Command queue empty |
| tx_count | input | 9 | TX FIFO occupancy |
| tx_full | input | 1 | TX FIFO full |
| tx_empty | input | 1 | TX FIFO empty |
| rx_count | input | 9 | RX FIFO occupancy |
| rx_full | input | 1 | RX FIFO full |
| rx_empty | input | 1 | RX FIFO empty |
| ev_rx_overflow | input | 1 | One-cycle RX overflow event |
| ev_tx_underflow | input | 1 | One-cycle TX underflow event |
| ev_mode_fail | input | 1 | One-cycle mode fault event |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties assume that at most one register write is presented per cycle and that an event pulse lasts a single clock. They also assume the counts and flags held between edges are consistent, with full and empty never both set. The stimulus changes inputs only on falling clock edges. It raises each event for exactly one cycle, and it always drives flag and count combinations that a real FIFO could present. Only the same-cycle set-and-clear case deliberately overlaps a write with an event.

// File: rtl/fic_pkg.sv
// Shared constants for the FIFO threshold interrupt controller.
// Bit positions of the status word are fixed because software decodes them.
package fic_pkg;
    localparam int STAT_W = 12;

    localparam int B_RX_OVF     = 0;
    localparam int B_MODE_FAIL  = 1;
    localparam int B_TX_NFULL   = 2;
    localparam int B_TX_FULL    = 3;
    localparam int B_RX_LEVEL   = 4;
    localparam int B_RX_FULL    = 5;
    localparam int B_TX_UNDF    = 6;
    localparam int B_CMD_EMPTY  = 7;
    localparam int B_TX_EMPTY   = 8;
    localparam int B_CMD_NFULL  = 9;
    localparam int B_CMD_FULL   = 10;
    localparam int B_RX_EMPTY   = 11;

    localparam logic [STAT_W-1:0] SRC_ENABLE  = 12'hFBE;
    localparam logic [STAT_W-1:0] STICKY_MASK = 12'h043;

    typedef enum logic [2:0] {
        A_STATUS  = 3'd0,
        A_UNMASK  = 3'd1,
        A_MASKSET = 3'd2,
        A_MASK    = 3'd3,
        A_TX_LVL  = 3'd4,
        A_RX_LVL  = 3'd5,
        A_CMD_LVL = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/fic_thresh_reg.sv
// Programmable threshold register.
// Assumes a synchronous active-low reset; resets to 1; takes the low W bits of a write.
module fic_thresh_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Hold the threshold; load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= W'(1);
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/fic_level_decode.sv
// Derives the level-type status bits from live FIFO counts, flags and thresholds.
// Purely combinational; sticky bit positions come out as zero.
module fic_level_decode
    import fic_pkg::*;
#(
    parameter int TXW  = 9,
    parameter int RXW  = 9,
    parameter int CMDW = 6
) (
    input  logic [TXW-1:0]    tx_count,
    input  logic [TXW-1:0]    tx_thr,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic [RXW-1:0]    rx_count,
    input  logic [RXW-1:0]    rx_thr,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic [CMDW-1:0]   cmd_count,
    input  logic [CMDW-1:0]   cmd_thr,
    input  logic              cmd_full,
    input  logic              cmd_empty,
    output logic [STAT_W-1:0] level
);
    // Compose every non-sticky status bit from the current FIFO state.
    always_comb begin
        level               = '0;
        level[B_TX_NFULL]   = (tx_count < tx_thr);
        level[B_TX_FULL]    = tx_full;
        level[B_TX_EMPTY]   = tx_empty;
        level[B_RX_LEVEL]   = (rx_count >= rx_thr);
        level[B_RX_FULL]    = rx_full;
        level[B_RX_EMPTY]   = rx_empty;
        level[B_CMD_NFULL]  = (cmd_count < cmd_thr);
        level[B_CMD_FULL]   = cmd_full;
        level[B_CMD_EMPTY]  = cmd_empty;
    end
endmodule

// File: rtl/fic_status_reg.sv
// Status register: per bit either sticky (set by event, cleared by write-1) or
// reloaded from the level vector each clock. Set beats clear in the same cycle.
module fic_status_reg
    import fic_pkg::*;
#(
    parameter logic [STAT_W-1:0] STICKY = STICKY_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] level,
    input  logic [STAT_W-1:0] set_ev,
    input  logic [STAT_W-1:0] clr,
    output logic [STAT_W-1:0] q
);
    logic [STAT_W-1:0] nxt;

    // Pick sticky or level behaviour per bit.
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            assign nxt[i] = set_ev[i] | (q[i] & ~clr[i]);
        end else begin : g_level
            assign nxt[i] = level[i];
        end
    end

    // Register the next status word.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/fic_mask_reg.sv
// Interrupt mask with separate set and clear strobes; 1 = source masked.
// Assumes set and clear are not both requested in one cycle (set applied last).
module fic_mask_reg
    import fic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] bits,
    output logic [STAT_W-1:0] q
);
    // Apply mask-set OR or unmask AND-NOT; reset masks all sources.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= SRC_ENABLE;
        else if (set_we) q <= q | bits;
        else if (clr_we) q <= q & ~bits;
    end
endmodule

// File: rtl/fifo_irq_ctrl.sv
// Top of the FIFO threshold interrupt controller: register port decode,
// threshold bank, status and mask registers, registered interrupt output.
// Assumes one register access per cycle and single-cycle event pulses.
module fifo_irq_ctrl
    import fic_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TX_DEPTH  = 256,
    parameter int RX_DEPTH  = 256,
    parameter int CMD_DEPTH = 32,
    localparam int TXW  = $clog2(TX_DEPTH + 1),
    localparam int RXW  = $clog2(RX_DEPTH + 1),
    localparam int CMDW = $clog2(CMD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CMDW-1:0]   cmd_count,
    input  logic              cmd_full,
    input  logic              cmd_empty,
    input  logic [TXW-1:0]    tx_count,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic [RXW-1:0]    rx_count,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic              ev_rx_overflow,
    input  logic              ev_tx_underflow,
    input  logic              ev_mode_fail,
    output logic              irq
);
    logic [TXW-1:0]    tx_thr_q;
    logic [RXW-1:0]    rx_thr_q;
    logic [CMDW-1:0]   cmd_thr_q;
    logic [STAT_W-1:0] level;
    logic [STAT_W-1:0] events;
    logic [STAT_W-1:0] stat_clr;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] mask_q;
    logic              irq_q;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:STAT_W];

    // Decode writes into per-register strobes.
    logic we_tx, we_rx, we_cmd, we_status, we_set, we_clr;
    always_comb begin
        we_tx     = reg_wr && (reg_addr == A_TX_LVL);
        we_rx     = reg_wr && (reg_addr == A_RX_LVL);
        we_cmd    = reg_wr && (reg_addr == A_CMD_LVL);
        we_status = reg_wr && (reg_addr == A_STATUS);
        we_set    = reg_wr && (reg_addr == A_MASKSET);
        we_clr    = reg_wr && (reg_addr == A_UNMASK);
    end

    fic_thresh_reg #(.W(TXW)) u_tx_thr (
        .clk(clk), .rst_n(rst_n), .we(we_tx), .wdata(reg_wdata[TXW-1:0]), .q(tx_thr_q));
    fic_thresh_reg #(.W(RXW)) u_rx_thr (
        .clk(clk), .rst_n(rst_n), .we(we_rx), .wdata(reg_wdata[RXW-1:0]), .q(rx_thr_q));
    fic_thresh_reg #(.W(CMDW)) u_cmd_thr (
        .clk(clk), .rst_n(rst_n), .we(we_cmd), .wdata(reg_wdata[CMDW-1:0]), .q(cmd_thr_q));

    fic_level_decode #(.TXW(TXW), .RXW(RXW), .CMDW(CMDW)) u_decode (
        .tx_count(tx_count), .tx_thr(tx_thr_q), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_count(rx_count), .rx_thr(rx_thr_q), .rx_full(rx_full), .rx_empty(rx_empty),
        .cmd_count(cmd_count), .cmd_thr(cmd_thr_q), .cmd_full(cmd_full),
        .cmd_empty(cmd_empty), .level(level));

    // Gather the event pulses into status-bit positions and form the clear vector.
    always_comb begin
        events              = '0;
        events[B_RX_OVF]    = ev_rx_overflow;
        events[B_MODE_FAIL] = ev_mode_fail;
        events[B_TX_UNDF]   = ev_tx_underflow;
        stat_clr            = we_status ? reg_wdata[STAT_W-1:0] : '0;
    end

    fic_status_reg #(.STICKY(STICKY_MASK)) u_status (
        .clk(clk), .rst_n(rst_n), .level(level), .set_ev(events),
        .clr(stat_clr), .q(status_q));

    fic_mask_reg u_mask (
        .clk(clk), .rst_n(rst_n), .set_we(we_set), .clr_we(we_clr),
        .bits(reg_wdata[STAT_W-1:0]), .q(mask_q));

    // Register the qualified interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(~mask_q & status_q & SRC_ENABLE);
    end
    assign irq = irq_q;

    // Return the addressed register, zero-extended.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS:  reg_rdata = DATA_W'(status_q);
            A_MASK:    reg_rdata = DATA_W'(mask_q);
            A_TX_LVL:  reg_rdata = DATA_W'(tx_thr_q);
            A_RX_LVL:  reg_rdata = DATA_W'(rx_thr_q);
            A_CMD_LVL: reg_rdata = DATA_W'(cmd_thr_q);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fic_irq_chk.sv
// Property checker for fifo_irq_ctrl, attached with bind below.
// Assumes single-cycle event pulses and one register write per cycle.
module fic_irq_chk
    import fic_pkg::*;
#(
    parameter int RXW = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [STAT_W-1:0] wbits,
    input logic [STAT_W-1:0] status_q,
    input logic [STAT_W-1:0] mask_q,
    input logic [RXW-1:0]    rx_count,
    input logic [RXW-1:0]    rx_thr,
    input logic              ev_rx_overflow,
    input logic              ev_mode_fail,
    input logic              ev_tx_underflow,
    input logic              irq
);
    // R1
    mask_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == SRC_ENABLE));

    // R3
    rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_q[B_RX_LEVEL] == ($past(rx_count) >= $past(rx_thr))));

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overflow |=> status_q[B_RX_OVF]);

    // R7
    mode_fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mode_fail |=> status_q[B_MODE_FAIL]);

    // R5
    undf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_underflow |=> status_q[B_TX_UNDF]);

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASKSET) |=> ((mask_q & $past(wbits)) == $past(wbits)));

    // R8
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_UNMASK) |=> ((mask_q & $past(wbits)) == '0));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == A_MASKSET || reg_addr == A_UNMASK)) |=> $stable(mask_q));

    // R9
    irq_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(~mask_q & status_q) & SRC_ENABLE)));

    // R10
    irq_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

bind fifo_irq_ctrl fic_irq_chk #(.RXW(RXW)) u_fic_irq_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wbits(reg_wdata[fic_pkg::STAT_W-1:0]), .status_q(status_q), .mask_q(mask_q),
    .rx_count(rx_count), .rx_thr(rx_thr_q), .ev_rx_overflow(ev_rx_overflow),
    .ev_mode_fail(ev_mode_fail), .ev_tx_underflow(ev_tx_underflow), .irq(irq));

// File: tb/test_fifo_irq_ctrl.sv
// Scoreboard bench: driver tasks queue expected items, a monitor pops and compares.
module test_fifo_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  cmd_count = '0;
    logic        cmd_full = 1'b0, cmd_empty = 1'b1;
    logic [8:0]  tx_count = '0;
    logic        tx_full = 1'b0, tx_empty = 1'b1;
    logic [8:0]  rx_count = '0;
    logic        rx_full = 1'b0, rx_empty = 1'b1;
    logic        ev_ovf = 1'b0, ev_undf = 1'b0, ev_mf = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  sample_ev;

    always #5 clk = ~clk;

    fifo_irq_ctrl i_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_count(cmd_count), .cmd_full(cmd_full), .cmd_empty(cmd_empty),
        .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
        .ev_rx_overflow(ev_ovf), .ev_tx_underflow(ev_undf), .ev_mode_fail(ev_mf),
        .irq(irq));

    // Monitor: pop expected items and compare against the outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'd0, irq} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        #1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
    endtask

    task automatic chk_irq_now(input logic e, input string tag);
        item_t it;
        #1;
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ev_ovf = 1'b1;
        if (which == 1) ev_mf = 1'b1;
        if (which == 6) ev_undf = 1'b1;
        @(negedge clk);
        ev_ovf = 1'b0; ev_mf = 1'b0; ev_undf = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: irq low while reset is sampled
        step(3);
        chk_irq_now(1'b0, "R10 irq in reset");
        rst_n = 1'b1;
        step(3);
        // R1 reset values
        chk_reg(3'd3, 32'h0000_0FBE, "R1 mask reset");
        chk_reg(3'd4, 32'd1, "R1 tx threshold reset");
        chk_reg(3'd5, 32'd1, "R1 rx threshold reset");
        chk_reg(3'd6, 32'd1, "R1 cmd threshold reset");
        chk_reg(3'd0, 32'h0000_0B84, "R1 status idle");
        chk_irq_now(1'b0, "R1 irq after reset");

        // R3/R4: occupied TX and RX
        @(negedge clk);
        rx_count = 9'd5; rx_empty = 1'b0; tx_count = 9'd8; tx_empty = 1'b0;
        step(2);
        chk_reg(3'd0, 32'h0000_0290, "R3 rx level, R4 tx above threshold");
        wr(3'd5, 32'd6);
        chk_reg(3'd0, 32'h0000_0280, "R3 rx count below threshold");
        wr(3'd5, 32'd5);
        chk_reg(3'd0, 32'h0000_0290, "R3 rx count equal to threshold");
        wr(3'd4, 32'd8);
        chk_reg(3'd0, 32'h0000_0290, "R4 tx count equal to threshold");
        wr(3'd4, 32'd9);
        chk_reg(3'd0, 32'h0000_0294, "R4 tx count below threshold");

        // R4 command threshold, R2 full flags
        @(negedge clk);
        cmd_count = 6'd3; cmd_empty = 1'b0;
        wr(3'd6, 32'd3);
        chk_reg(3'd0, 32'h0000_0014, "R4 cmd count equal to threshold");
        wr(3'd6, 32'd4);
        chk_reg(3'd0, 32'h0000_0214, "R4 cmd count below threshold");
        @(negedge clk);
        cmd_count = 6'd32; cmd_full = 1'b1; tx_full = 1'b1; rx_full = 1'b1;
        step(2);
        chk_reg(3'd0, 32'h0000_043C, "R2 all full flags");
        @(negedge clk);
        cmd_count = '0; cmd_full = 1'b0; cmd_empty = 1'b1;
        tx_count = '0; tx_full = 1'b0; tx_empty = 1'b1;
        rx_count = '0; rx_full = 1'b0; rx_empty = 1'b1;
        step(2);
        chk_reg(3'd0, 32'h0000_0B84, "R2 all empty flags");

        // R6: write-1 on level bits has no effect
        wr(3'd0, 32'h0000_0FFF);
        chk_reg(3'd0, 32'h0000_0B84, "R6 level bits survive clear");

        // R5 sticky events
        pulse(0);
        step(3);
        chk_reg(3'd0, 32'h0000_0B85, "R5 overflow sticky");
        pulse(1);
        pulse(6);
        step(2);
        chk_reg(3'd0, 32'h0000_0BC7, "R5 mode fail and underflow sticky");
        wr(3'd0, 32'h0000_0001);
        chk_reg(3'd0, 32'h0000_0BC6, "R6 clear overflow only");

        // R7 set wins over clear
        @(negedge clk);
        ev_mf = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h2;
        @(negedge clk);
        ev_mf = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        chk_reg(3'd0, 32'h0000_0BC6, "R7 set beats clear");
        wr(3'd0, 32'h0000_0042);
        chk_reg(3'd0, 32'h0000_0B84, "R6 clear remaining sticky bits");

        // R9 timing and R8 mask strobes
        wr(3'd1, 32'h0000_0004);
        chk_irq_now(1'b0, "R9 irq one cycle after unmask");
        step(1);
        chk_irq_now(1'b1, "R9 irq raised");
        chk_reg(3'd3, 32'h0000_0FBA, "R8 unmask clears bit");
        wr(3'd2, 32'h0000_0004);
        chk_reg(3'd3, 32'h0000_0FBE, "R8 mask-set ors bit");
        chk_irq_now(1'b0, "R9 irq dropped after mask");
        wr(3'd3, 32'h0000_0000);
        chk_reg(3'd3, 32'h0000_0FBE, "R8 mask address read-only");
        wr(3'd1, 32'hFFFF_FFFF);
        chk_reg(3'd3, 32'h0000_0000, "R8 unmask all");
        step(1);
        chk_irq_now(1'b1, "R9 irq with all unmasked");
        wr(3'd2, 32'hFFFF_FFFF);
        chk_reg(3'd3, 32'h0000_0FFF, "R8 mask-set all");
        step(1);
        chk_irq_now(1'b0, "R9 irq with all masked");

        // R9: bits 0 and 6 are not interrupt sources
        wr(3'd1, 32'h0000_0041);
        pulse(0);
        pulse(6);
        step(2);
        chk_irq_now(1'b0, "R9 overflow and underflow not sources");
        wr(3'd1, 32'h0000_0002);
        pulse(1);
        step(1);
        chk_irq_now(1'b1, "R9 mode fail raises irq");

        // R10/R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        step(1);
        chk_irq_now(1'b0, "R10 irq low after reset edge");
        step(1);
        rst_n = 1'b1;
        chk_reg(3'd3, 32'h0000_0FBE, "R1 mask after second reset");
        chk_reg(3'd4, 32'd1, "R1 tx threshold after second reset");

        step(2);
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule